// File: doc/BRIEF.md
# Breakpoint Acknowledge Responder

This block sits beside a processor on a simplified synchronous bus and answers its breakpoint acknowledge cycles. A cycle of this kind is marked by a cycle-type input that is high together with the address strobe. The 3-bit breakpoint number sits on address bits 4..2. The responder looks up the operation word stored for that breakpoint and drives it on the data bus. It raises a termination acknowledge, so the processor can execute that word in place of the breakpoint instruction.

Each of the eight breakpoints has its own saturating hit counter and its own terminal count. When a hit brings a breakpoint's counter up to its nonzero terminal count, a sticky halt request is raised for the debug host. A one-cycle write port loads replacement words and terminal counts. The same port clears single counters and clears the halt request.

Top module: `bkpt_responder`

## Requirements
- R1: After reset `bus_term`, `bus_oe` and `halt_req` are low and `bus_data` is zero; every stored word, terminal count and counter is zero.
- R2: A cycle is accepted on a rising edge that samples `bus_strobe` and `bus_bkack` both high while no cycle is in progress. `bus_term` and `bus_oe` are high from that edge on. A strobe without the cycle-type input, or the cycle-type input without a strobe, drives nothing and counts nothing.
- R3: `bus_term` and `bus_oe` stay high while `bus_strobe` stays high. They go low on the first edge that samples `bus_strobe` low. A strobe held high starts no second cycle.
- R4: While `bus_oe` is high, `bus_data` equals the word stored for the breakpoint number `bkpt_id` that was sampled at acceptance. While `bus_oe` is low, `bus_data` is zero.
- R5: A write is one edge with `cfg_we` high. `cfg_idx` selects the breakpoint and `cfg_sel` selects the action: 0 stores `cfg_wdata` as the word, 1 stores `cfg_wdata[7:0]` as the terminal count, 2 clears the counter, 3 clears the halt request.
- R6: Each accepted cycle adds one to the counter of its breakpoint. If the new value is at least the nonzero terminal count of that breakpoint, `halt_req` rises on the same edge as `bus_term`.
- R7: A breakpoint whose terminal count is zero never raises `halt_req`, however often it is hit.
- R8: `halt_req` stays high until a clear-halt write. If a hit that reaches its terminal count falls on the same edge as a clear-halt write, `halt_req` stays high.
- R9: A counter stops at 255 and does not wrap to zero.
- R10: A clear-counter write sets that one counter to zero and leaves the other counters alone. It wins over a hit on the same breakpoint on the same edge.
- R11: `bus_data` holds the word captured at acceptance until the cycle ends, even if that breakpoint's word is rewritten during the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_strobe | input | 1 | Address strobe of the processor bus |
| bus_bkack | input | 1 | Cycle type is breakpoint acknowledge |
| bkpt_id | input | 3 | Breakpoint number taken from address bits 4..2 |
| bus_data | output | 16 | Replacement operation word, zero when not driving |
| bus_oe | output | 1 | Data bus output enable |
| bus_term | output | 1 | Cycle termination acknowledge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write action: 0 word, 1 terminal count, 2 clear counter, 3 clear halt |
| cfg_idx | input | 3 | Breakpoint selected by the write |
| cfg_wdata | input | 16 | Write data |
| halt_req | output | 1 | Sticky halt request |

## Verification
Every result comes one edge after the edge that samples its cause. Acceptance on edge k drives the word, raises the acknowledge, bumps the counter and may set the halt request, all seen after edge k. Release follows the first edge that samples the strobe low, and a write takes effect on the edge that samples `cfg_we`. The bench changes inputs and samples outputs on falling edges, and its reference model steps on each rising edge. The model's state after edge k is therefore exactly what is compared half a cycle later. Same-edge collisions of a hit with a clear-halt, a clear-counter or a word write are set up on purpose to pin down which action wins.

// File: rtl/bkpt_pkg.sv
// Package: shared encodings for the breakpoint acknowledge responder.
// Assumes the write-port action field is two bits wide.
package bkpt_pkg;
    typedef enum logic [1:0] {
        CFG_WORD     = 2'd0,
        CFG_LIMIT    = 2'd1,
        CFG_CLRCNT   = 2'd2,
        CFG_CLRHALT  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/bkpt_cycle_fsm.sv
// Module: bkpt_cycle_fsm
// Recognises a breakpoint acknowledge cycle and keeps the acknowledge
// up until the strobe drops. Assumes synchronous, glitch-free bus inputs.
module bkpt_cycle_fsm #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic            bkack,
    input  logic [ID_W-1:0] id_in,
    output logic            accept,
    output logic [ID_W-1:0] accept_id,
    output logic            active
);
    logic active_q;

    // Start a cycle only when idle, so a held strobe is accepted once.
    always_comb begin
        accept    = !active_q && strobe && bkack;
        accept_id = id_in;
        active    = active_q;
    end

    // Cycle state: set on acceptance, cleared once the strobe is seen low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (accept) begin
            active_q <= 1'b1;
        end else if (active_q && !strobe) begin
            active_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bkpt_word_bank.sv
// Module: bkpt_word_bank
// Stores one replacement operation word per breakpoint and captures the
// selected word at acceptance. Assumes accept is high for one edge only.
module bkpt_word_bank #(
    parameter int ID_W = 3,
    parameter int OP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_idx,
    input  logic [OP_W-1:0] wr_data,
    input  logic            accept,
    input  logic [ID_W-1:0] accept_id,
    input  logic            active,
    output logic [OP_W-1:0] data_out
);
    localparam int NUM_BP = 1 << ID_W;

    logic [OP_W-1:0] word_q [NUM_BP];
    logic [OP_W-1:0] out_q;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_word
        // Word store for breakpoint g, loaded from the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (wr_en && wr_idx == ID_W'(g)) begin
                word_q[g] <= wr_data;
            end
        end
    end

    // Capture the pre-write word at acceptance and hold it for the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (accept) begin
            out_q <= word_q[accept_id];
        end
    end

    // Drive zero whenever the bus is not being driven.
    always_comb begin
        data_out = active ? out_q : '0;
    end
endmodule

// File: rtl/bkpt_hit_counters.sv
// Module: bkpt_hit_counters
// Saturating hit counter and terminal count per breakpoint, plus the
// sticky halt request. Assumes at most one acceptance per edge.
module bkpt_hit_counters #(
    parameter int ID_W  = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_we,
    input  logic             clr_cnt_we,
    input  logic             clr_halt,
    input  logic [ID_W-1:0]  idx,
    input  logic [CNT_W-1:0] lim_data,
    input  logic             accept,
    input  logic [ID_W-1:0]  accept_id,
    output logic             halt
);
    localparam int NUM_BP = 1 << ID_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [NUM_BP];
    logic [CNT_W-1:0] lim_q [NUM_BP];
    logic [NUM_BP-1:0] hit;
    logic halt_q;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        logic             inc;
        logic [CNT_W-1:0] cnt_next;

        // Saturating next value and terminal-count test for breakpoint g.
        always_comb begin
            inc      = accept && accept_id == ID_W'(g);
            cnt_next = (cnt_q[g] == CNT_MAX) ? cnt_q[g] : cnt_q[g] + 1'b1;
            hit[g]   = inc && lim_q[g] != '0 && cnt_next >= lim_q[g];
        end

        // Counter for breakpoint g; a clear beats a same-edge increment.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (clr_cnt_we && idx == ID_W'(g)) begin
                cnt_q[g] <= '0;
            end else if (inc) begin
                cnt_q[g] <= cnt_next;
            end
        end

        // Terminal count for breakpoint g; zero means never halt.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lim_q[g] <= '0;
            end else if (lim_we && idx == ID_W'(g)) begin
                lim_q[g] <= lim_data;
            end
        end
    end

    // Sticky halt request; a new hit beats a same-edge clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else if (|hit) begin
            halt_q <= 1'b1;
        end else if (clr_halt) begin
            halt_q <= 1'b0;
        end
    end

    always_comb halt = halt_q;
endmodule

// File: rtl/bkpt_responder.sv
// Module: bkpt_responder (top)
// Answers breakpoint acknowledge cycles with a stored operation word,
// counts hits per breakpoint and raises a sticky halt request.
// Assumes a synchronous strobe/acknowledge bus and a one-cycle write port.
module bkpt_responder #(
    parameter int ID_W  = 3,
    parameter int OP_W  = 16,
    parameter int CNT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_strobe,
    input  logic            bus_bkack,
    input  logic [ID_W-1:0] bkpt_id,
    output logic [OP_W-1:0] bus_data,
    output logic            bus_oe,
    output logic            bus_term,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [ID_W-1:0] cfg_idx,
    input  logic [OP_W-1:0] cfg_wdata,
    output logic            halt_req
);
    import bkpt_pkg::*;

    logic            accept;
    logic [ID_W-1:0] accept_id;
    logic            active;
    logic            we_word, we_lim, we_clrcnt, we_clrhalt;

    // Decode the write action.
    always_comb begin
        we_word    = cfg_we && cfg_sel_e'(cfg_sel) == CFG_WORD;
        we_lim     = cfg_we && cfg_sel_e'(cfg_sel) == CFG_LIMIT;
        we_clrcnt  = cfg_we && cfg_sel_e'(cfg_sel) == CFG_CLRCNT;
        we_clrhalt = cfg_we && cfg_sel_e'(cfg_sel) == CFG_CLRHALT;
    end

    bkpt_cycle_fsm #(.ID_W(ID_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .strobe(bus_strobe), .bkack(bus_bkack),
        .id_in(bkpt_id), .accept(accept), .accept_id(accept_id), .active(active)
    );

    bkpt_word_bank #(.ID_W(ID_W), .OP_W(OP_W)) i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(we_word), .wr_idx(cfg_idx),
        .wr_data(cfg_wdata), .accept(accept), .accept_id(accept_id),
        .active(active), .data_out(bus_data)
    );

    bkpt_hit_counters #(.ID_W(ID_W), .CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .lim_we(we_lim), .clr_cnt_we(we_clrcnt),
        .clr_halt(we_clrhalt), .idx(cfg_idx), .lim_data(cfg_wdata[CNT_W-1:0]),
        .accept(accept), .accept_id(accept_id), .halt(halt_req)
    );

    // Output enable and termination share the cycle state.
    always_comb begin
        bus_oe   = active;
        bus_term = active;
    end
endmodule

// File: rtl/bkpt_responder_chk.sv
// Module: bkpt_responder_chk
// Protocol checker bound to bkpt_responder; observes ports only.
module bkpt_responder_chk #(
    parameter int ID_W = 3,
    parameter int OP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_strobe,
    input logic            bus_bkack,
    input logic [OP_W-1:0] bus_data,
    input logic            bus_oe,
    input logic            bus_term,
    input logic            cfg_we,
    input logic [1:0]      cfg_sel,
    input logic            halt_req
);
    AST_TERM_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_term) |-> $past(bus_strobe && bus_bkack)); // R2
    AST_TERM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_term && bus_strobe) |=> bus_term); // R3
    AST_TERM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_term && !bus_strobe) |=> !bus_term); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_data == '0); // R4
    AST_HALT_WITH_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> $rose(bus_term)); // R6
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !(cfg_we && cfg_sel == 2'd3)) |=> halt_req); // R8
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_term && bus_strobe) |=> $stable(bus_data)); // R11
endmodule

bind bkpt_responder bkpt_responder_chk #(.ID_W(ID_W), .OP_W(OP_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_bkack(bus_bkack),
    .bus_data(bus_data), .bus_oe(bus_oe), .bus_term(bus_term),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .halt_req(halt_req)
);

// File: tb/test_bkpt_responder.sv
// Bench for bkpt_responder: behavioural reference model stepped on each
// rising edge, compared with the ports on each falling edge.
module test_bkpt_responder;
    localparam int ID_W = 3;
    localparam int OP_W = 16;
    localparam int CNT_W = 8;
    localparam int NBP = 8;
    localparam int CMAX = 255;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_strobe = 1'b0, bus_bkack = 1'b0;
    logic [ID_W-1:0] bkpt_id = '0;
    logic [OP_W-1:0] bus_data;
    logic bus_oe, bus_term, halt_req;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [ID_W-1:0] cfg_idx = '0;
    logic [OP_W-1:0] cfg_wdata = '0;

    int checks = 0, errors = 0, cyc = 0;
    string cur_req = "R1";
    bit done = 0;

    int m_word[NBP], m_lim[NBP], m_cnt[NBP];
    int m_data = 0;
    bit m_active = 0, m_halt = 0;

    always #2 clk = ~clk;

    bkpt_responder #(.ID_W(ID_W), .OP_W(OP_W), .CNT_W(CNT_W)) i_bkpt_responder (
        .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_bkack(bus_bkack),
        .bkpt_id(bkpt_id), .bus_data(bus_data), .bus_oe(bus_oe), .bus_term(bus_term),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .halt_req(halt_req)
    );

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        bit acc, hit, clrh;
        int nc;
        if (!rst_n) begin
            for (int i = 0; i < NBP; i++) begin
                m_word[i] = 0; m_lim[i] = 0; m_cnt[i] = 0;
            end
            m_active = 0; m_halt = 0; m_data = 0;
        end else begin
            acc = !m_active && bus_strobe && bus_bkack;
            hit = 0; clrh = 0;
            if (acc) begin
                nc = (m_cnt[bkpt_id] < CMAX) ? m_cnt[bkpt_id] + 1 : CMAX;
                hit = (m_lim[bkpt_id] != 0) && (nc >= m_lim[bkpt_id]);
                m_cnt[bkpt_id] = nc;
                m_active = 1;
                m_data = m_word[bkpt_id];
            end else if (m_active && !bus_strobe) begin
                m_active = 0;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_word[cfg_idx] = cfg_wdata;
                    2'd1: m_lim[cfg_idx] = cfg_wdata & CMAX;
                    2'd2: m_cnt[cfg_idx] = 0;
                    default: clrh = 1;
                endcase
            end
            if (hit) m_halt = 1;
            else if (clrh) m_halt = 0;
        end
    end

    task automatic check_eq(string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", cur_req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Per-cycle comparison with the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check_eq("term", int'(bus_term), int'(m_active));
            check_eq("oe", int'(bus_oe), int'(m_active));
            check_eq("data", int'(bus_data), m_active ? m_data : 0);
            check_eq("halt", int'(halt_req), int'(m_halt));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL %s watchdog got %0d exp %0d", cur_req, cyc, 150000);
            finish_run();
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(int sel, int idx, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = ID_W'(idx); cfg_wdata = OP_W'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic hit(int id, int hold);
        @(negedge clk);
        bus_strobe = 1'b1; bus_bkack = 1'b1; bkpt_id = ID_W'(id);
        repeat (hold + 1) @(negedge clk);
        bus_strobe = 1'b0; bus_bkack = 1'b0;
        @(negedge clk);
    endtask

    // Start a hit and a write on the same rising edge.
    task automatic hit_with_cfg(int id, int sel, int idx, int data);
        @(negedge clk);
        bus_strobe = 1'b1; bus_bkack = 1'b1; bkpt_id = ID_W'(id);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = ID_W'(idx); cfg_wdata = OP_W'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        bus_strobe = 1'b0; bus_bkack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        wait_cyc(4);
        @(negedge clk) rst_n = 1'b1;
        cur_req = "R1";
        @(negedge clk);
        check_eq("reset term", int'(bus_term), 0);
        check_eq("reset halt", int'(halt_req), 0);
        check_eq("reset data", int'(bus_data), 0);
        hit(3, 1);               // R1: words start at zero

        cur_req = "R5";
        for (int i = 0; i < NBP; i++) cfg(0, i, 16'hA000 + i * 16'h0111);
        cur_req = "R4";
        for (int i = 0; i < NBP; i++) hit(NBP - 1 - i, i % 3);

        cur_req = "R2";
        @(negedge clk) bus_strobe = 1'b1;
        wait_cyc(3);
        check_eq("strobe only term", int'(bus_term), 0);
        bus_strobe = 1'b0; bus_bkack = 1'b1;
        wait_cyc(3);
        check_eq("type only term", int'(bus_term), 0);
        bus_bkack = 1'b0;

        cur_req = "R3";
        hit(4, 6);
        hit(1, 0);

        cur_req = "R11";
        @(negedge clk);
        bus_strobe = 1'b1; bus_bkack = 1'b1; bkpt_id = 3'd6;
        wait_cyc(1);
        check_eq("captured word", int'(bus_data), 16'hA666);
        cfg(0, 6, 16'h5A5A);
        wait_cyc(1);
        check_eq("word after rewrite", int'(bus_data), 16'hA666);
        bus_strobe = 1'b0; bus_bkack = 1'b0;
        wait_cyc(1);
        hit(6, 0);

        cur_req = "R6";
        cfg(1, 2, 3);            // id 2 already hit once
        hit(2, 0);
        check_eq("halt below limit", int'(halt_req), 0);
        hit(2, 0);
        check_eq("halt at limit", int'(halt_req), 1);

        cur_req = "R8";
        hit(0, 1);
        check_eq("halt sticky", int'(halt_req), 1);
        cfg(3, 0, 0);
        check_eq("halt cleared", int'(halt_req), 0);
        hit_with_cfg(2, 3, 0, 0);
        check_eq("set beats clear", int'(halt_req), 1);
        cfg(3, 0, 0);

        cur_req = "R7";
        for (int i = 0; i < 10; i++) hit(5, 0);
        check_eq("zero limit no halt", int'(halt_req), 0);

        cur_req = "R10";
        cfg(2, 2, 0);
        cfg(1, 2, 2);
        hit(2, 0);
        check_eq("after clear one hit", int'(halt_req), 0);
        hit_with_cfg(2, 2, 2, 0);
        check_eq("clear beats hit", int'(halt_req), 1);
        cfg(3, 0, 0);
        hit(2, 0);
        check_eq("count restarted", int'(halt_req), 0);
        hit(2, 0);
        check_eq("count reached again", int'(halt_req), 1);
        cfg(3, 0, 0);

        cur_req = "R9";
        for (int i = 0; i < 260; i++) hit(7, 0);
        cfg(1, 7, 200);
        check_eq("no halt before hit", int'(halt_req), 0);
        hit(7, 0);
        check_eq("saturated count halts", int'(halt_req), 1);

        wait_cyc(4);
        finish_run();
    end
endmodule